// File: doc/BRIEF.md
# Pipelined Control Bit Carrier

This block generates the control bits for each instruction of a five-stage in-order integer pipeline and moves them forward with the instruction. A small main decoder turns the opcode in decode into a control bundle. The bundle is captured into the decode-to-execute register. It then passes through the execute-to-memory and memory-to-writeback registers. At each boundary the bits that the stage just used are dropped. Execute sees operand-select, destination-select and ALU-operation bits. Memory sees read, write and branch strobes. Writeback sees the register-write enable and the load-result select.

The hazard logic can request a bubble. The bundle that enters the decode-to-execute register is then all zeros, so the slot writes neither the register file nor memory. The block carries no datapath fields. The stage registers have no hold input and load on every rising clock edge.

Top module: `ctlPipeChain`

## Requirements
- R1: While `rst` is high at a rising edge, all three stage registers are cleared. From the following edge every output reads 0.
- R2: An opcode of 0x00 (register-register) gives `exRegDst`=1 and `exAluOp`=2'b10 one edge later, with `exAluSrc`=0. The memory strobes are 0 and the writeback outputs are `wbRegWrite`=1, `wbMemToReg`=0.
- R3: Opcode 0x23 (load) gives `exAluSrc`=1, `exRegDst`=0 and `exAluOp`=2'b00. It then gives `memRead`=1 with `memWrite` and `memBranch` at 0, then `wbMemToReg`=1 and `wbRegWrite`=1.
- R4: Opcode 0x2B (store) gives `exAluSrc`=1 and `exAluOp`=2'b00. It then gives `memWrite`=1 alone, then `wbRegWrite`=0 and `wbMemToReg`=0.
- R5: Opcode 0x04 (branch) gives `exAluOp`=2'b01 with `exAluSrc`=0 and `exRegDst`=0. It then gives `memBranch`=1 alone, and both writeback outputs are 0.
- R6: Any other opcode decodes to an all-zero bundle, so the slot behaves as a no-op in every later stage.
- R7: When `bubble` is high at an edge, the bundle captured into the decode-to-execute register is all zeros, whatever the opcode. It stays zero through the memory and writeback stages.
- R8: The memory-stage outputs at each edge equal the bits that the instruction held in execute one edge earlier.
- R9: The writeback outputs at each edge equal the writeback bits that the instruction held in the memory stage one edge earlier.
- R10: All stage registers load on every edge. Back-to-back instructions of different kinds therefore appear in consecutive cycles, with no slot repeated or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction in decode |
| bubble | input | 1 | Insert an all-zero control slot instead of the decoded bundle |
| exAluSrc | output | 1 | Execute: second ALU operand comes from the immediate |
| exRegDst | output | 1 | Execute: destination register taken from the third register field |
| exAluOp | output | 2 | Execute: ALU operation class (00 add, 01 subtract, 10 by function field) |
| memRead | output | 1 | Memory: data read strobe |
| memWrite | output | 1 | Memory: data write strobe |
| memBranch | output | 1 | Memory: instruction is a conditional branch |
| wbMemToReg | output | 1 | Writeback: select the loaded data as the result |
| wbRegWrite | output | 1 | Writeback: register file write enable |

## Verification
The hardest case to reach is a bubble that coincides with a load or store opcode, while other kinds of instructions are still in the memory and writeback stages. A bubble that suppressed the wrong bits or the wrong stage would go unseen if the pipe were idle. The stimulus therefore asserts `bubble` in the middle of back-to-back mixed opcodes, and also drives it under a pseudo-random pattern. The reference queue model checks, two and three edges later, that each neighbouring slot came out intact. A reset in the middle of the stream checks that instructions already in flight vanish at once from all three stages.

// File: rtl/ctlPipePkg.sv
package ctlPipePkg;
  parameter int ALU_OP_W = 2;

  localparam logic [ALU_OP_W-1:0] ALU_ADD   = 2'b00;
  localparam logic [ALU_OP_W-1:0] ALU_SUB   = 2'b01;
  localparam logic [ALU_OP_W-1:0] ALU_FUNCT = 2'b10;

  // Full bundle held between decode and execute
  typedef struct packed {
    logic                memToReg;
    logic                regWrite;
    logic                memRead;
    logic                memWrite;
    logic                branch;
    logic                aluSrc;
    logic                regDst;
    logic [ALU_OP_W-1:0] aluOp;
  } exCtlT;

  // Bits still needed after execute
  typedef struct packed {
    logic memToReg;
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic branch;
  } memCtlT;

  // Bits still needed after memory access
  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtlT;

  function automatic memCtlT dropExBits(exCtlT c);
    memCtlT m;
    m.memToReg = c.memToReg;
    m.regWrite = c.regWrite;
    m.memRead  = c.memRead;
    m.memWrite = c.memWrite;
    m.branch   = c.branch;
    return m;
  endfunction

  function automatic wbCtlT dropMemBits(memCtlT c);
    wbCtlT w;
    w.memToReg = c.memToReg;
    w.regWrite = c.regWrite;
    return w;
  endfunction
endpackage

// File: rtl/ctlMainDecoder.sv
module ctlMainDecoder
  import ctlPipePkg::*;
#(
  parameter int                    OPCODE_W  = 6,
  parameter logic [OPCODE_W-1:0]   OP_RTYPE  = 6'h00,
  parameter logic [OPCODE_W-1:0]   OP_LOAD   = 6'h23,
  parameter logic [OPCODE_W-1:0]   OP_STORE  = 6'h2B,
  parameter logic [OPCODE_W-1:0]   OP_BRANCH = 6'h04
) (
  input  logic [OPCODE_W-1:0] opcode,
  output exCtlT               ctl
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OP_RTYPE: begin
        ctl.regWrite = 1'b1;
        ctl.regDst   = 1'b1;
        ctl.aluOp    = ALU_FUNCT;
      end
      OP_LOAD: begin
        ctl.aluSrc   = 1'b1;
        ctl.memRead  = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluOp    = ALU_ADD;
      end
      OP_STORE: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
        ctl.aluOp    = ALU_ADD;
      end
      OP_BRANCH: begin
        ctl.branch   = 1'b1;
        ctl.aluOp    = ALU_SUB;
      end
      default: ctl = '0;  // unknown opcode: no-op bundle (R6)
    endcase
  end

  // Memory strobes are exclusive and a load always writes back its data
  always_comb begin
    a_r3_load_writes_back: assert (!ctl.memRead || (ctl.memToReg && ctl.regWrite));
    a_r4_store_no_regwrite: assert (!ctl.memWrite || !ctl.regWrite);
    a_r5_strobes_exclusive: assert ($onehot0({ctl.memRead, ctl.memWrite, ctl.branch}));
  end
endmodule

// File: rtl/ctlStageChain.sv
module ctlStageChain
  import ctlPipePkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bubble,
  input  exCtlT  decCtl,
  output exCtlT  exCtl,
  output memCtlT memCtl,
  output wbCtlT  wbCtl
);
  exCtlT  idExQ;
  memCtlT exMemQ;
  wbCtlT  memWbQ;
  exCtlT  idExD;

  // A bubble replaces the decoded bits with zeros
  assign idExD = bubble ? exCtlT'('0) : decCtl;

  always_ff @(posedge clk) begin
    if (rst) begin
      idExQ  <= '0;
      exMemQ <= '0;
      memWbQ <= '0;
    end else begin
      idExQ  <= idExD;
      exMemQ <= dropExBits(idExQ);
      memWbQ <= dropMemBits(exMemQ);
    end
  end

  assign exCtl  = idExQ;
  assign memCtl = exMemQ;
  assign wbCtl  = memWbQ;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (idExQ == '0 && exMemQ == '0 && memWbQ == '0));

  a_r7_bubble_zero: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (idExQ == '0));

  a_r8_mem_follows_ex: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (exMemQ.memRead == $past(idExQ.memRead) &&
              exMemQ.memWrite == $past(idExQ.memWrite) &&
              exMemQ.branch == $past(idExQ.branch) &&
              exMemQ.regWrite == $past(idExQ.regWrite)));

  a_r9_wb_follows_mem: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (memWbQ.regWrite == $past(exMemQ.regWrite) &&
              memWbQ.memToReg == $past(exMemQ.memToReg)));
endmodule

// File: rtl/ctlPipeChain.sv
module ctlPipeChain
  import ctlPipePkg::*;
#(
  parameter int OPCODE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPCODE_W-1:0] opcode,
  input  logic                bubble,
  output logic                exAluSrc,
  output logic                exRegDst,
  output logic [ALU_OP_W-1:0] exAluOp,
  output logic                memRead,
  output logic                memWrite,
  output logic                memBranch,
  output logic                wbMemToReg,
  output logic                wbRegWrite
);
  exCtlT  decCtl;
  exCtlT  exCtl;
  memCtlT memCtl;
  wbCtlT  wbCtl;

  ctlMainDecoder #(.OPCODE_W(OPCODE_W)) uDecoder (
    .opcode (opcode),
    .ctl    (decCtl)
  );

  ctlStageChain uChain (
    .clk    (clk),
    .rst    (rst),
    .bubble (bubble),
    .decCtl (decCtl),
    .exCtl  (exCtl),
    .memCtl (memCtl),
    .wbCtl  (wbCtl)
  );

  assign exAluSrc   = exCtl.aluSrc;
  assign exRegDst   = exCtl.regDst;
  assign exAluOp    = exCtl.aluOp;
  assign memRead    = memCtl.memRead;
  assign memWrite   = memCtl.memWrite;
  assign memBranch  = memCtl.branch;
  assign wbMemToReg = wbCtl.memToReg;
  assign wbRegWrite = wbCtl.regWrite;
endmodule

// File: tb/ctlPipeChain_test.sv
module ctlPipeChain_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h3F;
  logic       bubble = 1'b0;
  logic       exAluSrc, exRegDst, memRead, memWrite, memBranch, wbMemToReg, wbRegWrite;
  logic [1:0] exAluOp;

  int compared = 0;
  int mismatched = 0;
  string phaseTag = "";

  // Reference pipe: index 0 = execute, 1 = memory, 2 = writeback
  // Bit order: memToReg regWrite memRead memWrite branch aluSrc regDst aluOp[1:0]
  bit [8:0] refQ[$];
  string    tagQ[$];

  always #5 clk = ~clk;

  ctlPipeChain uut (
    .clk(clk), .rst(rst), .opcode(opcode), .bubble(bubble),
    .exAluSrc(exAluSrc), .exRegDst(exRegDst), .exAluOp(exAluOp),
    .memRead(memRead), .memWrite(memWrite), .memBranch(memBranch),
    .wbMemToReg(wbMemToReg), .wbRegWrite(wbRegWrite)
  );

  function automatic bit [8:0] refDecode(input bit [5:0] op, input bit bub);
    if (bub) return 9'b0;                        // R7
    case (op)
      6'h00: return 9'b0_1_0_0_0_0_1_10;         // R2
      6'h23: return 9'b1_1_1_0_0_1_0_00;         // R3
      6'h2B: return 9'b0_0_0_1_0_1_0_00;         // R4
      6'h04: return 9'b0_0_0_0_1_0_0_01;         // R5
      default: return 9'b0;                      // R6
    endcase
  endfunction

  function automatic string refTag(input bit [5:0] op, input bit bub);
    if (bub) return "R7";
    case (op)
      6'h00: return "R2";
      6'h23: return "R3";
      6'h2B: return "R4";
      6'h04: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      refQ.push_back(9'b0);
      tagQ.push_back("R1");
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        refQ[i] = 9'b0;
        tagQ[i] = "R1";
      end
    end else begin
      refQ.push_front(refDecode(opcode, bubble));
      tagQ.push_front(phaseTag != "" ? phaseTag : refTag(opcode, bubble));
      void'(refQ.pop_back());
      void'(tagQ.pop_back());
    end
  end

  task automatic checkOne(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string memTag;
    string wbTag;
    memTag = (tagQ[1] == "R1") ? "R1" : "R8";
    wbTag  = (tagQ[2] == "R1") ? "R1" : "R9";
    checkOne(tagQ[0], "execute", int'({exAluSrc, exRegDst, exAluOp}), int'(refQ[0][3:0]));
    checkOne(memTag, "memory", int'({memRead, memWrite, memBranch}), int'(refQ[1][6:4]));
    checkOne(wbTag, "writeback", int'({wbMemToReg, wbRegWrite}), int'(refQ[2][8:7]));
  endtask

  task automatic step(input bit [5:0] op, input bit bub);
    @(negedge clk);
    compareAll();
    opcode = op;
    bubble = bub;
  endtask

  initial begin
    int lfsr;
    bit [5:0] ops[6];
    ops = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h3F, 6'h08};
    // R1: reset state
    for (int i = 0; i < 3; i++) step(6'h00, 1'b0);
    rst = 1'b0;
    // R2..R6: each kind alone, followed by idle slots
    for (int k = 0; k < 6; k++) begin
      step(ops[k], 1'b0);
      for (int j = 0; j < 3; j++) step(6'h3F, 1'b0);
    end
    // R7: bubble on load and on store amid traffic
    step(6'h00, 1'b0);
    step(6'h23, 1'b1);
    step(6'h2B, 1'b1);
    step(6'h04, 1'b0);
    step(6'h00, 1'b1);
    for (int j = 0; j < 3; j++) step(6'h3F, 1'b0);
    // R10: back-to-back mixed kinds
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 4; k++) step(ops[k], 1'b0);
    // R1: reset in mid-stream drops in-flight slots
    step(6'h23, 1'b0);
    step(6'h00, 1'b0);
    rst = 1'b1;
    step(6'h2B, 1'b0);
    rst = 1'b0;
    step(6'h04, 1'b0);
    // Pseudo-random opcodes and bubbles
    lfsr = 32'h1ACE;
    for (int n = 0; n < 60; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      step(ops[lfsr % 6], (lfsr & 32'h30) == 32'h30);
    end
    for (int j = 0; j < 4; j++) step(6'h3F, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    mismatched++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule